// File: doc/BRIEF.md
# Registered Bidirectional Parity Transceiver

This block joins two 8-bit buses through two independent holding registers. A word written from the A side is latched into a forward register and then offered on the B side with a generated parity bit. A word written from the B side, together with its parity bit, is latched into a return register and then offered on the A side with a parity-error indication. Each direction has a data-ready flag. The writer's load sets the flag, and the reader's release of its output enable clears it, which gives a simple mailbox handshake between the two sides.

All pin-level strobes (the two load clocks and the two active-low output enables) are sampled on one free-running system clock. An edge is recognised as a sample of 1 following a sample of 0. Tri-state pin groups are modelled as a value bus plus an active-high drive enable.

Top module: `parity_xcvr`

## Requirements
- R1: A forward load happens when `fw_clk` is sampled 1 after a sample of 0 while `fw_load_n` is 0. The `a_in` value taken at that edge appears on `b_out` after that edge. After reset the previous sample of each strobe counts as 1.
- R2: When `fw_load_n` is 1, or `fw_clk` shows no 0-to-1 edge, the forward register keeps its value. The same rule applies to the return register with `rt_clk` and `rt_load_n`.
- R3: `fw_rdy` goes to 1 on the edge that performs a forward load.
- R4: `fw_rdy` goes to 0 on the edge where `b_en_n` is sampled 1 after a sample of 0. If a forward load falls on the same edge, `fw_rdy` is 1.
- R5: `b_oe` and `par_oe` equal the inverse of `b_en_n`. `b_out` always shows the forward register.
- R6: `par_out` is 1 when the forward register holds an even number of ones, including zero ones, and 0 when it holds an odd number.
- R7: A return load takes `b_in` into the return register and `par_in` into the stored parity bit. It sets `rt_rdy`, and the word appears on `a_out`. `a_oe` equals the inverse of `a_en_n`.
- R8: `rt_rdy` goes to 0 on a sampled 0-to-1 edge of `a_en_n`. A return load on the same edge takes priority and leaves `rt_rdy` at 1.
- R9: `err_out` is 1 while `a_en_n` is 1. While `a_en_n` is 0, `err_out` is 1 exactly when the return register and the stored parity bit together hold an odd number of ones.
- R10: The asynchronous active-low `rst_n` clears both registers, the stored parity bit and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Word arriving from the A side |
| fw_clk | input | 1 | Forward load strobe, acts on a rising edge |
| fw_load_n | input | 1 | Forward load enable, active low |
| b_en_n | input | 1 | B-side drive enable, active low; its release clears `fw_rdy` |
| b_out | output | 8 | Forward register value toward the B side |
| b_oe | output | 1 | B-side drive enable |
| par_out | output | 1 | Generated parity, 1 when even |
| par_oe | output | 1 | Drive enable of `par_out` |
| fw_rdy | output | 1 | Forward data-ready flag |
| b_in | input | 8 | Word arriving from the B side |
| par_in | input | 1 | Parity bit arriving with `b_in` |
| rt_clk | input | 1 | Return load strobe, acts on a rising edge |
| rt_load_n | input | 1 | Return load enable, active low |
| a_en_n | input | 1 | A-side drive enable, active low; its release clears `rt_rdy` |
| a_out | output | 8 | Return register value toward the A side |
| a_oe | output | 1 | A-side drive enable |
| err_out | output | 1 | Parity error, 1 on odd ones or when disabled |
| rt_rdy | output | 1 | Return data-ready flag |

## Verification
The hardest case to reach is the one where a load and a flag release land on the same sampled edge. Only then does the priority of set over clear become visible on the flag. Random toggling of the strobes hits this case only now and then, so directed sequences raise the load clock and release the output enable in the same cycle, for both directions. The random phase then mixes loads, holds with a blocked enable, and enable toggles against a bench model of both paths.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         fw_clk,
  input  logic         fw_load_n,
  input  logic         b_en_n,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic         par_out,
  output logic         par_oe,
  output logic         fw_rdy,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  input  logic         rt_clk,
  input  logic         rt_load_n,
  input  logic         a_en_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic         err_out,
  output logic         rt_rdy
);

  logic [W-1:0] fw_q, rt_q;
  logic         rt_par_q;
  logic         fw_clk_d, rt_clk_d, b_en_d, a_en_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fw_clk_d <= 1'b1;
      rt_clk_d <= 1'b1;
      b_en_d   <= 1'b1;
      a_en_d   <= 1'b1;
    end else begin
      fw_clk_d <= fw_clk;
      rt_clk_d <= rt_clk;
      b_en_d   <= b_en_n;
      a_en_d   <= a_en_n;
    end

  wire fw_ld  = fw_clk & ~fw_clk_d & ~fw_load_n;
  wire rt_ld  = rt_clk & ~rt_clk_d & ~rt_load_n;
  wire fw_rel = b_en_n & ~b_en_d;
  wire rt_rel = a_en_n & ~a_en_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fw_q   <= '0;
      fw_rdy <= 1'b0;
    end else begin
      if (fw_ld) fw_q <= a_in;
      if (fw_ld) fw_rdy <= 1'b1;
      else if (fw_rel) fw_rdy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rt_q     <= '0;
      rt_par_q <= 1'b0;
      rt_rdy   <= 1'b0;
    end else begin
      if (rt_ld) begin
        rt_q     <= b_in;
        rt_par_q <= par_in;
      end
      if (rt_ld) rt_rdy <= 1'b1;
      else if (rt_rel) rt_rdy <= 1'b0;
    end

  assign b_out   = fw_q;
  assign b_oe    = ~b_en_n;
  assign par_oe  = ~b_en_n;
  assign par_out = ~^fw_q;

  assign a_out   = rt_q;
  assign a_oe    = ~a_en_n;
  assign err_out = a_en_n | (^{rt_q, rt_par_q});

endmodule

// File: rtl/parity_xcvr_sva.sv
module parity_xcvr_sva #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         fw_clk,
  input logic         fw_load_n,
  input logic         b_en_n,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         par_out,
  input logic         par_oe,
  input logic         fw_rdy,
  input logic [W-1:0] b_in,
  input logic         par_in,
  input logic         rt_clk,
  input logic         rt_load_n,
  input logic         a_en_n,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic         err_out,
  input logic         rt_rdy
);

  a_r1_fw_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fw_clk) && !fw_load_n) |=> (b_out == $past(a_in)));

  a_r2_fw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(fw_clk) && !fw_load_n) |=> $stable(b_out));

  a_r2_rt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(rt_clk) && !rt_load_n) |=> $stable(a_out));

  a_r3_fw_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fw_clk) && !fw_load_n) |=> fw_rdy);

  a_r4_fw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_en_n) && !($rose(fw_clk) && !fw_load_n)) |=> !fw_rdy);

  a_r5_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe == b_oe);

  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    par_out == ($countones(b_out) % 2 == 0));

  a_r7_rt_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rt_clk) && !rt_load_n) |=> (a_out == $past(b_in)) && rt_rdy);

  a_r8_rt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_en_n) && !($rose(rt_clk) && !rt_load_n)) |=> !rt_rdy);

  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> err_out);

endmodule

bind parity_xcvr parity_xcvr_sva #(.W(W)) u_sva (.*);

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic fw_clk = 0, fw_load_n = 1, b_en_n = 1;
  logic rt_clk = 0, rt_load_n = 1, a_en_n = 1, par_in = 0;
  logic [7:0] b_out, a_out;
  logic b_oe, par_out, par_oe, fw_rdy, a_oe, err_out, rt_rdy;

  int n_chk = 0, n_bad = 0;

  logic [7:0] m_fw = 0, m_rt = 0;
  logic m_rp = 0, m_frdy = 0, m_rrdy = 0;
  logic p_fwc = 1, p_rtc = 1, p_ben = 1, p_aen = 1;

  always #5 clk = ~clk;

  parity_xcvr uut (.*);

  function automatic logic even1(input logic [7:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 b_out", b_out, m_fw);
    chk("R5 b_oe", {7'd0, b_oe}, {7'd0, ~b_en_n});
    chk("R5 par_oe", {7'd0, par_oe}, {7'd0, ~b_en_n});
    chk("R6 par_out", {7'd0, par_out}, {7'd0, even1(m_fw)});
    chk("R3 fw_rdy", {7'd0, fw_rdy}, {7'd0, m_frdy});
    chk("R7 a_out", a_out, m_rt);
    chk("R7 a_oe", {7'd0, a_oe}, {7'd0, ~a_en_n});
    chk("R9 err_out", {7'd0, err_out},
        {7'd0, a_en_n ? 1'b1 : ~even1(m_rt) ^ m_rp});
    chk("R8 rt_rdy", {7'd0, rt_rdy}, {7'd0, m_rrdy});
  endtask

  task automatic cycle();
    logic fl, rl;
    @(posedge clk);
    fl = fw_clk & ~p_fwc & ~fw_load_n;
    rl = rt_clk & ~p_rtc & ~rt_load_n;
    if (fl) m_fw = a_in;
    if (rl) begin m_rt = b_in; m_rp = par_in; end
    if (fl) m_frdy = 1; else if (b_en_n & ~p_ben) m_frdy = 0;
    if (rl) m_rrdy = 1; else if (a_en_n & ~p_aen) m_rrdy = 0;
    p_fwc = fw_clk; p_rtc = rt_clk; p_ben = b_en_n; p_aen = a_en_n;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R10: reset state, with both enables low to expose parity and error
    a_en_n = 0; b_en_n = 0;
    #1;
    chk("R10 b_out", b_out, 8'h00);
    chk("R10 a_out", a_out, 8'h00);
    chk("R10 par_out", {7'd0, par_out}, 8'h01);
    chk("R10 err_out", {7'd0, err_out}, 8'h00);
    chk("R10 flags", {6'd0, fw_rdy, rt_rdy}, 8'h00);
    rst_n = 1; p_ben = 1; p_aen = 1;
    cycle(); cycle();
    // R1 and R3: directed forward load
    a_in = 8'hA5; fw_load_n = 0; fw_clk = 1; cycle();
    fw_clk = 0; fw_load_n = 1; cycle();
    // R2: a rising edge with the enable high must not load
    a_in = 8'h3C; fw_clk = 1; cycle();
    chk("R2 blocked load", b_out, 8'hA5);
    fw_clk = 0; cycle();
    // R4: release clears the flag
    b_en_n = 1; cycle();
    chk("R4 cleared", {7'd0, fw_rdy}, 8'h00);
    // R4: simultaneous load and release keeps the flag set
    b_en_n = 0; cycle();
    a_in = 8'h01; fw_load_n = 0; fw_clk = 1; b_en_n = 1; cycle();
    chk("R4 set wins", {7'd0, fw_rdy}, 8'h01);
    fw_clk = 0; fw_load_n = 1; cycle();
    // R7 and R9: return load with odd total ones
    b_in = 8'h07; par_in = 0; rt_load_n = 0; rt_clk = 1; cycle();
    chk("R9 odd error", {7'd0, err_out}, 8'h01);
    rt_clk = 0; rt_load_n = 1; cycle();
    // R8: simultaneous return load and A release
    b_in = 8'hFF; par_in = 1; rt_load_n = 0; rt_clk = 1; a_en_n = 1; cycle();
    chk("R8 set wins", {7'd0, rt_rdy}, 8'h01);
    rt_clk = 0; rt_load_n = 1; a_en_n = 0; cycle();
    a_en_n = 1; cycle();
    chk("R8 cleared", {7'd0, rt_rdy}, 8'h00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      a_in      = 8'($urandom);
      b_in      = 8'($urandom);
      par_in    = 1'($urandom);
      fw_clk    = 1'($urandom);
      rt_clk    = 1'($urandom);
      fw_load_n = ($urandom % 4) == 0;
      rt_load_n = ($urandom % 4) == 0;
      if ($urandom % 3 == 0) b_en_n = ~b_en_n;
      if ($urandom % 3 == 0) a_en_n = ~a_en_n;
      cycle();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule